// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers up to 32 level-sensitive interrupt requests for a small processor. For each request line it keeps three views. The raw view is a registered copy of the line. The enable mask is changed through separate write-one-to-set and write-one-to-clear addresses. The pending view is a sticky latch that captures a request only while that request is enabled. One interrupt line to the processor is asserted while any pending bit is held.

Each source has its own two-state latch machine. `LAT_IDLE` moves to `LAT_PEND` on the transition *capture*, which happens when the raw bit and the enable bit are both 1. `LAT_PEND` moves back to `LAT_IDLE` on the transition *acknowledge*, which happens when software writes a 1 for that source to the pending-clear address. No other event leaves `LAT_PEND`, so a peripheral that drops its line, for example after its data has been read, does not lose the request.

A second machine serves the register bus. `BUS_IDLE` moves to `BUS_RESP` on a read request (*read-issue*). `BUS_RESP` stays in `BUS_RESP` on a back-to-back read and returns to `BUS_IDLE` otherwise (*read-done*). Read data are presented in the cycle after the request, and reading never changes any state.

Top module: `irqc_top`

## Requirements
- R1: During and right after reset, the raw, enable and pending registers read as 0, `irq` is 0 and `bus_rvalid` is 0.
- R2: The raw register, read at address 0, holds the value of `src_req` from the previous clock cycle. It returns to 0 one cycle after a source deasserts.
- R3: A pending bit becomes 1 on the clock edge at which its raw bit and its enable bit are both 1. A pending bit never becomes 1 otherwise.
- R4: A pending bit that is set stays set after its raw bit returns to 0, until it is acknowledged.
- R5: Writing to address 2 sets the enable bits where the write data hold 1. Writing to address 3 clears them. Bits where the data hold 0 are unchanged. The mask is read at address 1.
- R6: Clearing an enable bit stops new captures for that source but leaves a pending bit that is already set.
- R7: Writing 1s to address 5 clears those pending bits on that edge, even if a capture is due at the same edge. If the raw and enable bits are still 1, the bit is set again on the following edge.
- R8: A read (`bus_sel`=1, `bus_wr`=0) returns the addressed register, as it stood at the request edge, on `bus_rdata` with `bus_rvalid`=1 in the next cycle. Reads change no register, so repeated reads of the pending register at address 4 agree.
- R9: `irq` is the OR of all pending bits, registered: it changes one cycle after the pending register changes.
- R10: Reads of addresses 6 and 7 return 0. Writes to addresses 0, 1 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Level request lines, one per source |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq | output | 1 | Interrupt to the processor |

## Verification
Two functions can fall in the same cycle: an acknowledge write to the pending-clear address, and a capture caused by a request that is still raised and still enabled. The bench provokes this by acknowledging a source while its line stays high. It expects the bit to read 0 in the cycle after the write and to read 1 again one cycle later. A random phase also overlaps enable-mask writes, acknowledges and request edges. A reference model compares `irq`, `bus_rvalid` and the read data against the design on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_RAW      = 3'd0,
        REG_ENABLE   = 3'd1,
        REG_EN_SET   = 3'd2,
        REG_EN_CLR   = 3'd3,
        REG_PEND     = 3'd4,
        REG_PEND_CLR = 3'd5
    } reg_addr_e;

    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_PEND = 1'b1
    } lat_state_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irqc_src_latch.sv
module irqc_src_latch
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_bit,
    input  logic en_bit,
    input  logic ack_bit,
    output logic pend_bit
);

    lat_state_e state_q;
    lat_state_e state_d;

    // next-state: acknowledge has priority over capture in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE: begin
                if (!ack_bit && raw_bit && en_bit) begin
                    state_d = LAT_PEND;   // capture
                end
            end
            LAT_PEND: begin
                if (ack_bit) begin
                    state_d = LAT_IDLE;   // acknowledge
                end
            end
            default: state_d = LAT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LAT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pend_bit = (state_q == LAT_PEND);
    end

endmodule

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_mask,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] en_vec
);

    logic [NUM_SRC-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | set_mask) & ~clr_mask;
        end
    end

    assign en_vec = en_q;

endmodule

// File: rtl/irqc_bus_if.sv
module irqc_bus_if
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [NUM_SRC-1:0] raw_vec,
    input  logic [NUM_SRC-1:0] en_vec,
    input  logic [NUM_SRC-1:0] pend_vec,
    output logic [NUM_SRC-1:0] en_set,
    output logic [NUM_SRC-1:0] en_clr,
    output logic [NUM_SRC-1:0] pend_ack,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               bus_rvalid
);

    bus_state_e         state_q;
    bus_state_e         state_d;
    logic               rd_req;
    logic               wr_req;
    logic [BUS_W-1:0]   rd_mux;
    logic [BUS_W-1:0]   rdata_q;

    assign rd_req = bus_sel && !bus_wr;
    assign wr_req = bus_sel &&  bus_wr;

    // write decode into per-source strobes
    always_comb begin
        en_set   = '0;
        en_clr   = '0;
        pend_ack = '0;
        if (wr_req) begin
            unique case (bus_addr)
                REG_EN_SET:   en_set   = bus_wdata[NUM_SRC-1:0];
                REG_EN_CLR:   en_clr   = bus_wdata[NUM_SRC-1:0];
                REG_PEND_CLR: pend_ack = bus_wdata[NUM_SRC-1:0];
                default: ;
            endcase
        end
    end

    // read select, zero-extended to bus width
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            REG_RAW:    rd_mux[NUM_SRC-1:0] = raw_vec;
            REG_ENABLE: rd_mux[NUM_SRC-1:0] = en_vec;
            REG_PEND:   rd_mux[NUM_SRC-1:0] = pend_vec;
            default:    rd_mux = '0;
        endcase
    end

    // read-issue / read-done transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               irq
);

    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] en_set;
    logic [NUM_SRC-1:0] en_clr;
    logic [NUM_SRC-1:0] pend_ack;
    logic               irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= src_req;
        end
    end

    irqc_en_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_en_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (en_set),
        .clr_mask (en_clr),
        .en_vec   (en_vec)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irqc_src_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_bit  (raw_q[g]),
            .en_bit   (en_vec[g]),
            .ack_bit  (pend_ack[g]),
            .pend_bit (pend_vec[g])
        );
    end

    irqc_bus_if #(
        .NUM_SRC (NUM_SRC)
    ) u_bus_if (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .raw_vec    (raw_q),
        .en_vec     (en_vec),
        .pend_vec   (pend_vec),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .pend_ack   (pend_ack),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pend_vec;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_req,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] en,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en_set,
    input logic [NUM_SRC-1:0] ack,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic               bus_rvalid,
    input logic               irq
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !armed |-> (pend == '0 && !irq && !bus_rvalid)) else $error("reset"); // R1

    AST_RAW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (raw == $past(src_req))) else $error("raw"); // R2

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((pend & $past(raw & en & ~ack)) == $past(raw & en & ~ack))) else $error("capture"); // R3

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((pend & ~$past(pend) & ~$past(raw & en)) == '0)) else $error("spurious"); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((pend & $past(pend & ~ack)) == $past(pend & ~ack))) else $error("sticky"); // R4

    AST_EN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((en & ~$past(en) & ~$past(en_set)) == '0)) else $error("enable"); // R5

    AST_ACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((pend & $past(ack)) == '0)) else $error("ack"); // R7

    AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (bus_rvalid == $past(bus_sel && !bus_wr))) else $error("rvalid"); // R8

    AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (irq == (|$past(pend)))) else $error("irq"); // R9

endmodule

bind irqc_top irqc_checker #(
    .NUM_SRC (NUM_SRC)
) u_irqc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .raw        (raw_q),
    .en         (en_vec),
    .pend       (pend_vec),
    .en_set     (en_set),
    .ack        (pend_ack),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rvalid (bus_rvalid),
    .irq        (irq)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        irq;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    logic [31:0] m_raw = '0, m_en = '0, m_pend = '0, m_rdata = '0;
    bit          m_irq = 0, m_rvalid = 0;

    always #2 clk = ~clk;

    irqc_top #(.NUM_SRC(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] wset, wclr, wack, rv;
        bit rd, wr;
        rd = bus_sel && !bus_wr;
        wr = bus_sel && bus_wr;
        wset = (wr && bus_addr == 3'd2) ? bus_wdata : 32'h0;
        wclr = (wr && bus_addr == 3'd3) ? bus_wdata : 32'h0;
        wack = (wr && bus_addr == 3'd5) ? bus_wdata : 32'h0;
        case (bus_addr)
            3'd0: rv = m_raw;
            3'd1: rv = m_en;
            3'd4: rv = m_pend;
            default: rv = 32'h0;
        endcase
        if (rd) m_rdata = rv;
        m_rvalid = rd;
        m_irq    = (m_pend != 0);
        m_pend   = (m_pend | (m_raw & m_en)) & ~wack;
        m_en     = (m_en | wset) & ~wclr;
        m_raw    = src_req;
    endtask

    // one cycle: inputs already set, model follows the edge, compare at negedge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R9 irq vs model", {31'h0, irq}, {31'h0, m_irq});
        chk("R8 rvalid vs model", {31'h0, bus_rvalid}, {31'h0, m_rvalid});
        if (m_rvalid) chk("R8 rdata vs model", bus_rdata, m_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bus_sel = 0; bus_wr = 0;
            tick();
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        tick();
        bus_sel = 0;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq in reset", {31'h0, irq}, 32'h0);
        chk("R1 rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
        rst_n = 1'b1;
        idle(1);
        rd(3'd0, 32'h0, "R1 raw after reset");
        rd(3'd1, 32'h0, "R1 enable after reset");
        rd(3'd4, 32'h0, "R1 pend after reset");

        // R2 raw follows; R3 no capture while disabled
        src_req = 32'h8;
        idle(2);
        rd(3'd0, 32'h8, "R2 raw shows source");
        rd(3'd4, 32'h0, "R3 no capture while disabled");

        // R5 enable set; R3 capture; R9 irq
        wr(3'd2, 32'h28);
        idle(1);
        rd(3'd1, 32'h28, "R5 enable set");
        rd(3'd4, 32'h8, "R3 capture when enabled");
        chk("R9 irq raised", {31'h0, irq}, 32'h1);

        // R4 sticky, R8 repeated reads agree
        src_req = 32'h0;
        idle(2);
        rd(3'd0, 32'h0, "R2 raw drops");
        rd(3'd4, 32'h8, "R4 pend sticky");
        rd(3'd4, 32'h8, "R8 repeat read unchanged");

        // R6 disable keeps pend, bit5 still captures
        wr(3'd3, 32'h8);
        src_req = 32'h28;
        idle(2);
        rd(3'd4, 32'h28, "R6 disabled bit kept, enabled bit captured");
        rd(3'd1, 32'h20, "R5 enable clear");

        // R7 ack collides with capture of bit5
        wr(3'd5, 32'h28);
        rd(3'd4, 32'h0, "R7 ack wins in its cycle");
        rd(3'd4, 32'h20, "R7 recapture next cycle");

        // R9 irq falls after final ack
        src_req = 32'h0;
        idle(1);
        wr(3'd5, 32'h20);
        chk("R9 irq still high one cycle", {31'h0, irq}, 32'h1);
        idle(1);
        chk("R9 irq dropped", {31'h0, irq}, 32'h0);

        // R10 read-only writes ignored, unmapped reads zero
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd4, 32'h0, "R10 pend write ignored");
        rd(3'd1, 32'h20, "R10 enable direct write ignored");
        rd(3'd0, 32'h0, "R10 raw write ignored");
        src_req = 32'hA5A5_0000;
        idle(1);
        rd(3'd6, 32'h0, "R10 unmapped read 6");
        rd(3'd7, 32'h0, "R10 unmapped read 7");

        // random phase, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            src_req  = $urandom & $urandom & $urandom;
            op       = $urandom_range(0, 3);
            bus_sel  = (op != 0);
            bus_wr   = (op >= 2);
            bus_addr = 3'($urandom_range(0, 7));
            bus_wdata = $urandom & $urandom;
            tick();
        end
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule